// File: doc/BRIEF.md
# Signed Array Multiplier

This block multiplies two two's-complement operands of `WIDTH` bits each and returns their signed product on `2*WIDTH` bits. It is purely combinational. The product follows the operands within the same cycle, with no register on the path.

Each partial-product bit is a single AND of one multiplicand bit and one multiplier bit. Sign extension is avoided by the Baugh-Wooley rearrangement. The cross terms that pair exactly one operand sign bit with a non-sign bit are complemented. The sign-by-sign term and the plain terms go in unchanged. Two constant ones are then injected, at weight `2^WIDTH` and at weight `2^(2*WIDTH-1)`.

The resulting rows are reduced by a carry-save array of full-adder cells. A final ripple adder made of one half adder and a chain of full adders resolves the remaining sum and carry vectors. Any carry past the top product bit is dropped, so the arithmetic is modulo `2^(2*WIDTH)`. `WIDTH` must be at least 2.

Top module: `baugh_wooley_mul`

## Requirements
- R1: For every pair of `WIDTH`-bit two's-complement operands, `product_o` equals their signed product, written as a `2*WIDTH`-bit two's-complement value. The operand MSB has weight `-2^(WIDTH-1)`, and the other bits have weight `+2^i`.
- R2: Squaring the most negative operand (MSB 1, all other bits 0) gives `+2^(2*WIDTH-2)`: bit `2*WIDTH-2` is set and every other bit is clear.
- R3: When either operand is zero, `product_o` is all zeros, whatever the other operand is.
- R4: A multiplier of all ones (value -1) gives the two's-complement negation of the sign-extended multiplicand. This includes the most negative multiplicand, whose result is `+2^(WIDTH-1)`.
- R5: When both operands are non-zero, bit `2*WIDTH-1` of `product_o` equals the XOR of the two operand MSBs.
- R6: R1 holds for a non-default width of 8 bits (16-bit product), on random operands and on the corner values.
- R7: The block has no latency. When the operands change in every cycle, each product is correct in the same cycle as its operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| multiplicand_i | input | WIDTH | First two's-complement operand |
| multiplier_i | input | WIDTH | Second two's-complement operand |
| product_o | output | 2*WIDTH | Signed product, two's complement |

## Verification
At the default width of 4 bits, all 256 operand pairs are applied. This covers every mix of signs and separates a correct inversion pattern from one that complements the wrong cross terms or places a constant at the wrong weight. Zero operands, a multiplier of -1 and the most-negative square are tagged on their own. They show separately whether the constants cancel exactly, whether negation carries through the top bit, and whether the single positive extreme product is reached. A second instance at 8 bits takes random pairs plus the extreme values, with a new pair in every cycle. This shows that the generate structure scales and that no result lags its operands.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  // Product width for a given operand width.
  function automatic int prod_width(input int width);
    return 2 * width;
  endfunction

  // A partial-product bit is complemented when exactly one of its two
  // factors is an operand sign bit.
  function automatic bit pp_is_inverted(input int col, input int row, input int width);
    return ((col == width - 1) != (row == width - 1));
  endfunction

  // Weight of the low correction constant.
  function automatic int low_const_pos(input int width);
    return width;
  endfunction

endpackage

// File: rtl/bwm_fa.sv
module bwm_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  assign s_o  = a_i ^ b_i ^ c_i;
  assign co_o = (a_i & b_i) | (c_i & (a_i | b_i));
endmodule

// File: rtl/bwm_ha.sv
module bwm_ha (
  input  logic a_i,
  input  logic b_i,
  output logic s_o,
  output logic co_o
);
  assign s_o  = a_i ^ b_i;
  assign co_o = a_i & b_i;
endmodule

// File: rtl/bwm_pp_gen.sv
// Partial-product rows: row j holds x_i & y_j at column i+j, with the
// sign-crossing terms complemented.
module bwm_pp_gen #(
  parameter int WIDTH = 4,
  localparam int PW = bwm_pkg::prod_width(WIDTH)
) (
  input  logic [WIDTH-1:0]         x_i,
  input  logic [WIDTH-1:0]         y_i,
  output logic [WIDTH-1:0][PW-1:0] rows_o
);
  for (genvar j = 0; j < WIDTH; j++) begin : g_row
    for (genvar k = 0; k < PW; k++) begin : g_col
      if (k >= j && k < j + WIDTH) begin : g_term
        localparam bit INV = bwm_pkg::pp_is_inverted(k - j, j, WIDTH);
        if (INV) begin : g_inv
          assign rows_o[j][k] = ~(x_i[k-j] & y_i[j]);
        end else begin : g_pos
          assign rows_o[j][k] = x_i[k-j] & y_i[j];
        end
      end else begin : g_empty
        assign rows_o[j][k] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bwm_csa_array.sv
// Carry-save reduction of the rows plus the constant row, then a ripple
// adder on the final sum/carry pair. Carries out of the top column drop.
module bwm_csa_array #(
  parameter int WIDTH = 4,
  localparam int PW = bwm_pkg::prod_width(WIDTH)
) (
  input  logic [WIDTH-1:0][PW-1:0] rows_i,
  output logic [PW-1:0]            sum_o
);
  localparam logic [PW-1:0] ONE  = {{(PW-1){1'b0}}, 1'b1};
  localparam logic [PW-1:0] KROW = (ONE << bwm_pkg::low_const_pos(WIDTH)) | (ONE << (PW - 1));

  logic [WIDTH-1:0][PW-1:0] s_vec;
  logic [WIDTH-1:0][PW-1:0] c_vec;

  assign s_vec[0] = rows_i[0];
  assign c_vec[0] = KROW;

  for (genvar j = 1; j < WIDTH; j++) begin : g_lvl
    assign c_vec[j][0] = 1'b0;
    for (genvar k = 0; k < PW - 1; k++) begin : g_cell
      bwm_fa u_fa (
        .a_i  (s_vec[j-1][k]),
        .b_i  (c_vec[j-1][k]),
        .c_i  (rows_i[j][k]),
        .s_o  (s_vec[j][k]),
        .co_o (c_vec[j][k+1])
      );
    end
    // top column: sum only
    assign s_vec[j][PW-1] = s_vec[j-1][PW-1] ^ c_vec[j-1][PW-1] ^ rows_i[j][PW-1];
  end

  // Final carry-propagate adder; column 0 never holds a carry.
  logic [PW-1:2] rc;
  assign sum_o[0] = s_vec[WIDTH-1][0];

  bwm_ha u_ha (
    .a_i  (s_vec[WIDTH-1][1]),
    .b_i  (c_vec[WIDTH-1][1]),
    .s_o  (sum_o[1]),
    .co_o (rc[2])
  );

  for (genvar k = 2; k < PW - 1; k++) begin : g_rip
    bwm_fa u_fa (
      .a_i  (s_vec[WIDTH-1][k]),
      .b_i  (c_vec[WIDTH-1][k]),
      .c_i  (rc[k]),
      .s_o  (sum_o[k]),
      .co_o (rc[k+1])
    );
  end

  assign sum_o[PW-1] = s_vec[WIDTH-1][PW-1] ^ c_vec[WIDTH-1][PW-1] ^ rc[PW-1];
endmodule

// File: rtl/baugh_wooley_mul.sv
module baugh_wooley_mul #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]   multiplicand_i,
  input  logic [WIDTH-1:0]   multiplier_i,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int PW = bwm_pkg::prod_width(WIDTH);

  logic [WIDTH-1:0][PW-1:0] rows;

  bwm_pp_gen #(.WIDTH(WIDTH)) u_pp (
    .x_i    (multiplicand_i),
    .y_i    (multiplier_i),
    .rows_o (rows)
  );

  bwm_csa_array #(.WIDTH(WIDTH)) u_arr (
    .rows_i (rows),
    .sum_o  (product_o)
  );
endmodule

// File: rtl/bwm_checker.sv
module bwm_checker #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0]   multiplicand_i,
  input logic [WIDTH-1:0]   multiplier_i,
  input logic [2*WIDTH-1:0] product_o
);
  localparam int PW = 2 * WIDTH;
  localparam logic [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [PW-1:0] MINSQ = {2'b01, {(PW-2){1'b0}}};

  logic signed [PW-1:0] ext_a, ext_b, ref_p;

  always_comb begin
    ext_a = {{WIDTH{multiplicand_i[WIDTH-1]}}, multiplicand_i};
    ext_b = {{WIDTH{multiplier_i[WIDTH-1]}}, multiplier_i};
    ref_p = ext_a * ext_b;
    AST_PRODUCT_MATCH: assert (product_o == ref_p) // R1
      else $error("product mismatch");
    AST_MIN_SQUARE: assert (!(multiplicand_i == MINV && multiplier_i == MINV) || product_o == MINSQ) // R2
      else $error("min square wrong");
    AST_ZERO_OPERAND: assert (!(multiplicand_i == '0 || multiplier_i == '0) || product_o == '0) // R3
      else $error("zero operand gave nonzero");
    AST_NEG_ONE: assert (!(&multiplier_i) || product_o == -ext_a) // R4
      else $error("negation wrong");
    AST_SIGN_RULE: assert (multiplicand_i == '0 || multiplier_i == '0 ||
                           product_o[PW-1] == (multiplicand_i[WIDTH-1] ^ multiplier_i[WIDTH-1])) // R5
      else $error("sign wrong");
  end
endmodule

bind baugh_wooley_mul bwm_checker #(.WIDTH(WIDTH)) u_bwm_chk (
  .multiplicand_i (multiplicand_i),
  .multiplier_i   (multiplier_i),
  .product_o      (product_o)
);

// File: tb/baugh_wooley_mul_tb.sv
module baugh_wooley_mul_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  p4;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;

  baugh_wooley_mul #(.WIDTH(4)) u_dut (
    .multiplicand_i (a4), .multiplier_i (b4), .product_o (p4));
  baugh_wooley_mul #(.WIDTH(8)) u_dut8 (
    .multiplicand_i (a8), .multiplier_i (b8), .product_o (p8));

  typedef struct {
    int          w;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  function automatic int sval(input int v, input int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  function automatic logic [15:0] expect_p(input int a, input int b, input int w);
    int p;
    p = sval(a, w) * sval(b, w);
    return (w == 4) ? {8'h00, 8'(p)} : 16'(p);
  endfunction

  task automatic drive4(input int a, input int b, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    a4 = 4'(a); b4 = 4'(b);
    it.w = 4; it.exp = expect_p(a, b, 4); it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic drive8(input int a, input int b, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    a8 = 8'(a); b8 = 8'(b);
    it.w = 8; it.exp = expect_p(a, b, 8); it.tag = tag;
    sb_q.push_back(it);
  endtask

  function automatic string tag4(input int a, input int b);
    if (a == 8 && b == 8) return "R2";
    if (a == 0 || b == 0) return "R3";
    if (b == 15)          return "R4";
    return "R1/R5";
  endfunction

  // monitor: compares at the falling edge of the cycle the item was driven
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = sb_q.pop_front();
        act = (it.w == 4) ? {8'h00, p4} : p8;
        n_tests++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s w=%0d actual=%h expected=%h", it.tag, it.w, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: operands at zero give zero (R3)
    @(negedge clk);
    n_tests++;
    if (p4 !== 8'h00) begin
      n_fail++;
      $display("FAIL R3 reset actual=%h expected=00", p4);
    end
    // exhaustive 4-bit sweep (R1..R5, new pair each cycle: R7)
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        drive4(a, b, tag4(a, b));
    drive4(8, 8, "R2");
    drive4(8, 15, "R4");
    drive4(7, 8, "R5");
    // 8-bit instance: corners then random (R6, R7)
    drive8(128, 128, "R6/R2");
    drive8(128, 255, "R6/R4");
    drive8(127, 127, "R6");
    drive8(127, 128, "R6");
    drive8(0, 200, "R6/R3");
    for (int n = 0; n < 400; n++)
      drive8(int'($urandom_range(255)), int'($urandom_range(255)), "R6/R7");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule